// File: doc/BRIEF.md
# Floppy Output Register and Change-Line Controller

This block is the support register that sits beside a floppy disk controller's command sequencer. Software writes one byte to it. The byte carries four motor enables, a DMA enable, an active-low soft reset and a two-bit drive select. The drive select and the DMA enable override the matching fields in commands. On each write the block compares the new byte with the last one and acts only on the bits that changed. A write before any other write counts every bit as changed.

A falling edge on the reset bit sends a partial-reset strobe to the sequencer and forces status byte 0 to zero. A rising edge puts the sequencer into its result phase with a single result byte, `0xC0 | (st0In & 0x3F)`, and arms a short interrupt delay. When the motor of the sequencer's current unit changes, the not-ready bit (bit 3) of status byte 0 is updated and a long interrupt delay is armed. If that motor stops while a command is running, the command is aborted and status bits 7:6 are set. The block also drives the input register that reports the disk-change line for the selected drive.

Top module: `fdd_outreg`

## Requirements
- R1: While reset is held and until the first write, regEnabled, motorOn, dmaOverride, unitOverride, every strobe, irqFire and dirData are all 0.
- R2: After a write sampled at a clock edge, the outputs follow from that edge. motorOn equals wrData[7:4], with bit 4+n driving unit n. dmaOverride equals wrData[3]. unitOverride equals wrData[1:0]. regEnabled is 1.
- R3: The first write after reset counts every bit as changed. A first write with bit 2 high acts as a rising edge of the reset bit. A first write with bit 2 low acts as a falling edge.
- R4: A falling edge of bit 2 gives a one-cycle seqResetPulse, together with st0Wr, st0Next = 0x00 and no resultLoad.
- R5: A rising edge of bit 2 gives a one-cycle resultLoad with st0Wr and st0Next = 0xC0 | (x & 0x3F). Here x is st0In after any motor update from the same write. The short interrupt delay is armed.
- R6: A write that changes a motor bit makes the current unit's effective motor state (its enable AND drvPresent) differ from before. Such a write pulses st0Wr. st0Next bit 3 is cleared when the motor starts and set when it stops. The long interrupt delay is armed.
- R7: If such a change stops the motor while seqBusy is 1, abortExec pulses for one cycle and st0Next bits 7:6 are 1.
- R8: After the first write, a write that changes only bit 3 or bits 1:0 gives no strobe and arms no interrupt.
- R9: A motor-bit change that does not change the effective motor state of unit curUnit gives no st0Wr and arms no interrupt. Examples are another unit's motor, or a drive that is absent.
- R10: irqFire pulses for one cycle D clock edges after the arming edge. D is SHORT_DLY or LONG_DLY. If both are armed by one write, the short delay wins. Arming again restarts the countdown and cancels the pending pulse.
- R11: With sel = unitOverride, dirData is 0x80 only when regEnabled, drvPresent[sel], motorOn[sel] are all 1 and either drvReady[sel] is 0 or drvChanged[sel] is 1. Otherwise dirData is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the output register |
| wrData | input | 8 | Byte written |
| curUnit | input | 2 | Sequencer's current unit |
| seqBusy | input | 1 | Sequencer is inside a command (main status upper nibble not 0x8) |
| st0In | input | 8 | Sequencer's present status byte 0 |
| drvPresent | input | 4 | Drive n is attached |
| drvReady | input | 4 | Drive n reports ready |
| drvChanged | input | 4 | Drive n reports a media change |
| regEnabled | output | 1 | Register has been written since reset |
| motorOn | output | 4 | Motor enables |
| dmaOverride | output | 1 | DMA enable overriding command mode bit |
| unitOverride | output | 2 | Drive select overriding command unit field |
| seqResetPulse | output | 1 | Partial reset of sequencer and change lines |
| resultLoad | output | 1 | Enter result phase with one byte (st0Next) |
| abortExec | output | 1 | End the execution phase now |
| st0Wr | output | 1 | Load st0Next into status byte 0 |
| st0Next | output | 8 | New status byte 0 value |
| irqFire | output | 1 | Delayed interrupt pulse |
| dirData | output | 8 | Input register value (change line in bit 7) |

## Verification
The register fields and every strobe change on the clock edge that samples the write. The bench checks them at the falling edge that follows. dirData is combinational in the current inputs and the stored register, so it is checked in the same half-cycle. irqFire is due exactly SHORT_DLY or LONG_DLY edges after the arming write. A cycle-by-cycle reference countdown in the bench compares irqFire at every falling edge, so both an early pulse and a late pulse are flagged.

// File: rtl/fdd_outreg_pkg.sv
package fdd_outreg_pkg;
  localparam int unsigned UNITS = 4;

  typedef struct packed {
    logic regWr;
    logic motorChg;
    logic motorOnNow;
    logic abort;
    logic rstFall;
    logic rstRise;
    logic schedShort;
    logic schedLong;
  } fdoStrobes_t;
endpackage

// File: rtl/fdd_outreg_ctl.sv
module fdd_outreg_ctl
  import fdd_outreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [7:0]        regVal,
  input  logic              regValid,
  input  logic [1:0]        curUnit,
  input  logic [UNITS-1:0]  drvPresent,
  input  logic              seqBusy,
  output fdoStrobes_t       stb
);
  logic [7:0]       oldVal;
  logic [7:0]       chg;
  logic [UNITS-1:0] oldMotor;
  logic [UNITS-1:0] newMotor;
  logic             oldAct;
  logic             newAct;

  always_comb begin
    oldVal   = regValid ? regVal : ~wrData;
    chg      = wrData ^ oldVal;
    oldMotor = regVal[7:4];
    newMotor = wrData[7:4];
    oldAct   = oldMotor[curUnit] & drvPresent[curUnit];
    newAct   = newMotor[curUnit] & drvPresent[curUnit];

    stb            = '0;
    stb.regWr      = wrEn;
    stb.motorChg   = wrEn && (|chg[7:4]) && (oldAct != newAct);
    stb.motorOnNow = newAct;
    stb.abort      = stb.motorChg && !newAct && seqBusy;
    stb.rstFall    = wrEn && chg[2] && !wrData[2];
    stb.rstRise    = wrEn && chg[2] && wrData[2];
    stb.schedShort = stb.rstRise;
    stb.schedLong  = stb.motorChg;
  end

  // R8: override-only writes after the first one produce no action
  a_r8_override_only_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regValid && wrData[7:4] == regVal[7:4] && wrData[2] == regVal[2])
      |-> !(stb.rstFall || stb.rstRise || stb.motorChg || stb.schedShort || stb.schedLong));

  // R7: abort only ever accompanies a motor stop
  a_r7_abort_needs_stop: assert property (@(posedge clk) disable iff (!rstN)
    stb.abort |-> (stb.motorChg && !stb.motorOnNow));
endmodule

// File: rtl/fdd_outreg_dp.sv
module fdd_outreg_dp
  import fdd_outreg_pkg::*;
#(
  parameter int unsigned SHORT_DLY = 4,
  parameter int unsigned LONG_DLY  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  fdoStrobes_t       stb,
  input  logic [7:0]        wrData,
  input  logic [7:0]        st0In,
  input  logic [UNITS-1:0]  drvPresent,
  input  logic [UNITS-1:0]  drvReady,
  input  logic [UNITS-1:0]  drvChanged,
  output logic [7:0]        regVal,
  output logic              regValid,
  output logic              seqResetPulse,
  output logic              resultLoad,
  output logic              abortExec,
  output logic              st0Wr,
  output logic [7:0]        st0Next,
  output logic              irqFire,
  output logic [7:0]        dirData
);
  localparam int unsigned MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       st0Calc;
  logic [1:0]       sel;
  logic [UNITS-1:0] motorBits;

  always_comb begin
    st0Calc = st0In;
    if (stb.motorChg) st0Calc[3] = ~stb.motorOnNow;
    if (stb.abort)    st0Calc    = st0Calc | 8'hC0;
    if (stb.rstRise)  st0Calc    = 8'hC0 | (st0Calc & 8'h3F);
    if (stb.rstFall)  st0Calc    = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regVal        <= '0;
      regValid      <= 1'b0;
      seqResetPulse <= 1'b0;
      resultLoad    <= 1'b0;
      abortExec     <= 1'b0;
      st0Wr         <= 1'b0;
      st0Next       <= '0;
      cnt           <= '0;
      irqFire       <= 1'b0;
    end else begin
      seqResetPulse <= stb.rstFall;
      resultLoad    <= stb.rstRise;
      abortExec     <= stb.abort;
      st0Wr         <= stb.motorChg | stb.rstRise | stb.rstFall;
      if (stb.motorChg | stb.rstRise | stb.rstFall) st0Next <= st0Calc;
      if (stb.regWr) begin
        regVal   <= wrData;
        regValid <= 1'b1;
      end
      irqFire <= 1'b0;
      if (stb.schedShort)     cnt <= CNT_W'(SHORT_DLY);
      else if (stb.schedLong) cnt <= CNT_W'(LONG_DLY);
      else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) irqFire <= 1'b1;
      end
    end
  end

  assign sel       = regVal[1:0];
  assign motorBits = regVal[7:4];
  assign dirData   = {regValid & drvPresent[sel] & motorBits[sel]
                      & (~drvReady[sel] | drvChanged[sel]), 7'b0};

  // R2: a sampled write is visible from the next cycle
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    stb.regWr |=> (regValid && regVal == $past(wrData)));

  // R4: partial reset clears status byte 0 and excludes a result load
  a_r4_reset_clears_st0: assert property (@(posedge clk) disable iff (!rstN)
    seqResetPulse |-> (st0Wr && st0Next == 8'h00 && !resultLoad));

  // R5: leaving reset loads a result with the top two status bits set
  a_r5_result_top_bits: assert property (@(posedge clk) disable iff (!rstN)
    resultLoad |-> (st0Wr && st0Next[7:6] == 2'b11));

  // R7: an abort reports the stop in status byte 0
  a_r7_abort_status: assert property (@(posedge clk) disable iff (!rstN)
    (abortExec && !seqResetPulse) |-> (st0Next[7:6] == 2'b11 && st0Next[3]));

  // R10: countdown steps by one when not re-armed
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (cnt > CNT_W'(1) && !stb.schedShort && !stb.schedLong) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R10: the pulse appears only on expiry
  a_r10_fire_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    irqFire |-> ($past(cnt) == CNT_W'(1) && cnt == '0));

  // R11: the input register only ever uses bit 7
  always_comb begin
    a_r11_dir_bit7_only: assert (dirData[6:0] == 7'b0);
  end
endmodule

// File: rtl/fdd_outreg.sv
module fdd_outreg
  import fdd_outreg_pkg::*;
#(
  parameter int unsigned SHORT_DLY = 4,
  parameter int unsigned LONG_DLY  = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic [1:0] curUnit,
  input  logic       seqBusy,
  input  logic [7:0] st0In,
  input  logic [3:0] drvPresent,
  input  logic [3:0] drvReady,
  input  logic [3:0] drvChanged,
  output logic       regEnabled,
  output logic [3:0] motorOn,
  output logic       dmaOverride,
  output logic [1:0] unitOverride,
  output logic       seqResetPulse,
  output logic       resultLoad,
  output logic       abortExec,
  output logic       st0Wr,
  output logic [7:0] st0Next,
  output logic       irqFire,
  output logic [7:0] dirData
);
  fdoStrobes_t stb;
  logic [7:0]  regVal;
  logic        regValid;

  fdd_outreg_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .regVal(regVal), .regValid(regValid), .curUnit(curUnit),
    .drvPresent(drvPresent), .seqBusy(seqBusy), .stb(stb)
  );

  fdd_outreg_dp #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .st0In(st0In),
    .drvPresent(drvPresent), .drvReady(drvReady), .drvChanged(drvChanged),
    .regVal(regVal), .regValid(regValid), .seqResetPulse(seqResetPulse),
    .resultLoad(resultLoad), .abortExec(abortExec), .st0Wr(st0Wr),
    .st0Next(st0Next), .irqFire(irqFire), .dirData(dirData)
  );

  assign regEnabled   = regValid;
  assign motorOn      = regVal[7:4];
  assign dmaOverride  = regVal[3];
  assign unitOverride = regVal[1:0];
endmodule

// File: tb/tb_fdd_outreg.sv
module tb_fdd_outreg;
  localparam int SHORT_DLY = 4;
  localparam int LONG_DLY  = 24;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrData;
  logic [1:0] curUnit;
  logic       seqBusy;
  logic [7:0] st0In;
  logic [3:0] drvPresent, drvReady, drvChanged;
  logic       regEnabled, dmaOverride, seqResetPulse, resultLoad, abortExec, st0Wr, irqFire;
  logic [3:0] motorOn;
  logic [1:0] unitOverride;
  logic [7:0] st0Next, dirData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [7:0] mVal;
  logic       mValid;
  int         mCnt;
  logic [7:0] mSt0;
  logic eSeqRst, eRes, eAbort, eSt0Wr, eIrq;

  always #10 clk = ~clk;

  fdd_outreg #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .curUnit(curUnit),
    .seqBusy(seqBusy), .st0In(st0In), .drvPresent(drvPresent), .drvReady(drvReady),
    .drvChanged(drvChanged), .regEnabled(regEnabled), .motorOn(motorOn),
    .dmaOverride(dmaOverride), .unitOverride(unitOverride), .seqResetPulse(seqResetPulse),
    .resultLoad(resultLoad), .abortExec(abortExec), .st0Wr(st0Wr), .st0Next(st0Next),
    .irqFire(irqFire), .dirData(dirData)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expDir();
    logic [1:0] s;
    s = mVal[1:0];
    if (mValid && drvPresent[s] && mVal[4+s] && (!drvReady[s] || drvChanged[s])) return 8'h80;
    return 8'h00;
  endfunction

  task automatic modelEdge();
    logic [7:0] old, chg, s;
    logic oldA, newA, mc;
    int sched;
    eSeqRst = 0; eRes = 0; eAbort = 0; eSt0Wr = 0; eIrq = 0; sched = 0;
    if (!rstN) begin
      mVal = 0; mValid = 0; mCnt = 0; mSt0 = 0;
      return;
    end
    if (wrEn) begin
      old  = mValid ? mVal : ~wrData;
      chg  = wrData ^ old;
      oldA = mVal[4+curUnit] & drvPresent[curUnit];
      newA = wrData[4+curUnit] & drvPresent[curUnit];
      mc   = (|chg[7:4]) && (oldA != newA);
      s    = st0In;
      if (mc) begin
        s[3] = !newA;
        sched = 2;
        if (!newA && seqBusy) begin s = s | 8'hC0; eAbort = 1; end
      end
      if (chg[2] && wrData[2]) begin s = 8'hC0 | (s & 8'h3F); eRes = 1; sched = 1; end
      if (chg[2] && !wrData[2]) begin s = 8'h00; eSeqRst = 1; end
      if (mc || eRes || eSeqRst) begin eSt0Wr = 1; mSt0 = s; end
      mVal = wrData; mValid = 1;
    end
    if (sched == 1) mCnt = SHORT_DLY;
    else if (sched == 2) mCnt = LONG_DLY;
    else if (mCnt != 0) begin
      if (mCnt == 1) eIrq = 1;
      mCnt--;
    end
  endtask

  // one clock: model the edge, wait for it, compare at the falling edge
  task automatic step();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    checkEq("R2 motorOn", motorOn, mVal[7:4]);
    checkEq("R2 dmaOverride", dmaOverride, mVal[3]);
    checkEq("R2 unitOverride", unitOverride, mVal[1:0]);
    checkEq("R2 regEnabled", regEnabled, mValid);
    checkEq("R4 seqResetPulse", seqResetPulse, eSeqRst);
    checkEq("R5 resultLoad", resultLoad, eRes);
    checkEq("R6 st0Wr", st0Wr, eSt0Wr);
    if (eSt0Wr) checkEq("R6 st0Next", st0Next, mSt0);
    checkEq("R7 abortExec", abortExec, eAbort);
    checkEq("R10 irqFire", irqFire, eIrq);
    checkEq("R11 dirData", dirData, expDir());
  endtask

  task automatic doWrite(input logic [7:0] d);
    wrEn = 1; wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic applyReset();
    rstN = 0; wrEn = 0;
    idle(3);
    rstN = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; wrData = 0; curUnit = 0; seqBusy = 0; st0In = 8'h05;
    drvPresent = 4'hF; drvReady = 4'hF; drvChanged = 4'h0;
    mVal = 0; mValid = 0; mCnt = 0; mSt0 = 0;
    applyReset();
    // R1: reset state
    checkEq("R1 regEnabled", regEnabled, 0);
    checkEq("R1 motorOn", motorOn, 0);
    checkEq("R1 strobes", {seqResetPulse, resultLoad, abortExec, st0Wr, irqFire}, 0);
    drvReady = 4'h0; drvChanged = 4'hF;
    idle(1);
    checkEq("R1 dirData before first write", dirData, 8'h00);
    drvReady = 4'hF; drvChanged = 4'h0;

    // R3: first write, bit 2 high, motor 0 on -> result C5, short irq wins
    doWrite(8'h14);
    checkEq("R3 first write rising", resultLoad, 1);
    checkEq("R5 result byte", st0Next, 8'hC5);
    idle(SHORT_DLY + 2);

    // R8: only dma and unit bits change
    doWrite(8'h1D);
    checkEq("R8 no strobes", {seqResetPulse, resultLoad, abortExec, st0Wr}, 0);
    idle(LONG_DLY + 2);
    checkEq("R8 no irq armed", irqFire, 0);

    // R9: motor of another unit, and an absent current drive
    curUnit = 0;
    doWrite(8'h5C);
    checkEq("R9 other unit quiet", st0Wr, 0);
    curUnit = 3; drvPresent = 4'h7;
    doWrite(8'hDC);
    checkEq("R9 absent drive quiet", st0Wr, 0);
    idle(LONG_DLY + 2);
    drvPresent = 4'hF; curUnit = 0;

    // R6 and R7: stop unit 0 motor while busy
    seqBusy = 1; st0In = 8'h01;
    doWrite(8'hCC);
    checkEq("R7 abort", abortExec, 1);
    checkEq("R7 st0", st0Next, 8'hC9);
    seqBusy = 0;
    // R10 restart: start again before expiry
    idle(5);
    st0In = 8'h08;
    doWrite(8'hDC);
    checkEq("R6 start clears bit3", st0Next, 8'h00);
    idle(LONG_DLY + 2);

    // R4: falling edge of bit 2
    doWrite(8'hD8);
    checkEq("R4 partial reset", seqResetPulse, 1);
    idle(3);

    // R11 directed: select unit 1 with its motor on
    doWrite(8'h2D);
    drvReady = 4'hD; idle(1);
    checkEq("R11 not ready", dirData, 8'h80);
    drvReady = 4'hF; idle(1);
    checkEq("R11 ready unchanged", dirData, 8'h00);
    drvChanged = 4'h2; idle(1);
    checkEq("R11 media changed", dirData, 8'h80);
    drvPresent = 4'hD; idle(1);
    checkEq("R11 absent drive", dirData, 8'h00);
    drvPresent = 4'hF; drvChanged = 0;
    idle(LONG_DLY + 2);

    // R3: first write with bit 2 low acts as falling edge
    applyReset();
    doWrite(8'h00);
    checkEq("R3 first write falling", seqResetPulse, 1);

    // random phase
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 3000; i++) begin
      wrEn = ($urandom % 3) == 0;
      wrData = 8'($urandom);
      if (($urandom % 4) == 0) curUnit = 2'($urandom);
      seqBusy = 1'($urandom);
      st0In = 8'($urandom);
      drvPresent = 4'($urandom) | 4'h1;
      drvReady = 4'($urandom);
      drvChanged = 4'($urandom);
      step();
    end
    wrEn = 0;
    idle(LONG_DLY + 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule